// File: doc/BRIEF.md
# Two-Way Cache Lookup with Per-Set Way Prediction

This block is a read lookup unit for a two-way set-associative cache. Each set stores one prediction bit that names the way expected to hit on the next access to that set. When a request is accepted, the following cycle reads both ways, steers the data multiplexer from the prediction before any tag result is known, and compares only the predicted way's tag against the request. A match answers in that cycle. If the predicted tag does not match, the other way's tag is compared on the next cycle. A match there answers in the second cycle. If neither way matches, a refill is requested from the next level and the returned word is written into the least-recently-used way.

The requester sees a variable hit latency. A response kind code tells a fast hit, a slow hit and a miss apart. Addresses are word addresses. The low `IDX_W` bits select the set and the remaining bits form the tag. A block is one data word. The prediction bit and the replacement bit of a set are both written on every hit and every refill: the prediction takes the way just used and the replacement bit takes the other way.

The controller has four states:
- `S_IDLE` waits for a request and moves to `S_PRIMARY` on acceptance.
- `S_PRIMARY` compares the predicted way. On a match it returns to `S_IDLE`, or stays in `S_PRIMARY` when a new request is accepted in that same cycle. On a mismatch it moves to `S_ALTERNATE`.
- `S_ALTERNATE` compares the other way. On a match it goes to `S_IDLE`, otherwise to `S_REFILL`.
- `S_REFILL` holds the refill request until refill data arrives, then returns to `S_IDLE`.

Top module: `waypred_cache`

## Requirements
- R1: After reset the unit is ready, gives no response, does not request a refill, and holds no valid lines.
- R2: When the predicted way matches, the response appears in the cycle right after acceptance with kind code 1 (fast) and the stored word.
- R3: When only the other way matches, the response appears two cycles after acceptance with kind code 2 (slow), and the set's prediction then names the way that hit, so the next access to that line is fast.
- R4: When no way matches, the refill request rises three cycles after acceptance and holds the request address until refill data is valid. In that same cycle the response has kind code 3 (miss) and carries the refill word.
- R5: A refill is written into the set's least-recently-used way. Afterwards the prediction names the refilled way and the other way becomes the replacement victim.
- R6: Request-ready is high in `S_IDLE` and in a fast-hit cycle, and low during the second-way check and the whole refill.
- R7: A request accepted in a fast-hit cycle is looked up in the very next cycle, so fast hits can stream at one per cycle.
- R8: Refill-data-valid asserted while no refill is pending produces no response and changes no stored line.
- R9: The response kind is 0 whenever no response is valid, and nonzero whenever one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Request accepted at this edge when valid |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | 0 none, 1 fast hit, 2 slow hit, 3 miss |
| rsp_data | output | DATA_W | Response word |
| fill_req | output | 1 | Refill wanted from the next level |
| fill_addr | output | ADDR_W | Address being refilled |
| fill_valid | input | 1 | Refill word present |
| fill_data | input | DATA_W | Refill word |

## Verification
On every cycle, the assertions check that the kind code agrees with response-valid, that fast and slow responses follow the right ready history, that a pending refill holds its address and keeps ready low, and that a miss response only appears with refill data. Only the bench scenarios can show which way a refill evicts, that a mispredicted line turns fast on its next access, that back-to-back fast hits stream, and that a stray refill pulse corrupts nothing. The bench shows these by comparing data and kind against a behavioural model of tags, predictions and replacement bits over directed and pseudo-random address streams.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_PRIMARY   = 2'd1,
        S_ALTERNATE = 2'd2,
        S_REFILL    = 2'd3
    } wpc_state_e;

    localparam logic [1:0] KIND_NONE = 2'd0;
    localparam logic [1:0] KIND_FAST = 2'd1;
    localparam logic [1:0] KIND_SLOW = 2'd2;
    localparam logic [1:0] KIND_MISS = 2'd3;

    localparam int NUM_WAYS = 2;
endpackage

// File: rtl/wpc_ways.sv
module wpc_ways #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [IDX_W-1:0]                         rd_idx,
    output logic [wpc_pkg::NUM_WAYS-1:0]             rd_valid,
    output logic [wpc_pkg::NUM_WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [wpc_pkg::NUM_WAYS-1:0][DATA_W-1:0] rd_data,
    input  logic                                     wr_en,
    input  logic                                     wr_way,
    input  logic [IDX_W-1:0]                         wr_idx,
    input  logic [TAG_W-1:0]                         wr_tag,
    input  logic [DATA_W-1:0]                        wr_data
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < wpc_pkg::NUM_WAYS; w++) begin : g_way
        logic [SETS-1:0]   line_vld;
        logic [TAG_W-1:0]  line_tag [SETS];
        logic [DATA_W-1:0] line_dat [SETS];
        logic              sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_vld <= '0;
            end else if (sel) begin
                line_vld[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                line_tag[wr_idx] <= wr_tag;
                line_dat[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = line_vld[rd_idx];
        assign rd_tag[w]   = line_tag[rd_idx];
        assign rd_data[w]  = line_dat[rd_idx];
    end
endmodule

// File: rtl/wpc_hint.sv
module wpc_hint #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             pred_way,
    output logic             lru_way,
    input  logic             upd_en,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (upd_en) begin
            pred_q[idx] <= upd_way;
            lru_q[idx]  <= ~upd_way;
        end
    end

    assign pred_way = pred_q[idx];
    assign lru_way  = lru_q[idx];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              pred_way,
    input  logic              lru_way,
    input  logic              cmp_hit,
    input  logic              fill_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cmp_way,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic              use_fill,
    output logic              fill_req,
    output logic              upd_en,
    output logic              upd_way,
    output logic              wr_en,
    output logic              wr_way
);
    wpc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              alt_q, alt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            alt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            alt_q   <= alt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        alt_d   = alt_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = S_PRIMARY;
                    addr_d  = req_addr;
                end
            end
            S_PRIMARY: begin
                if (cmp_hit) begin
                    if (req_valid) begin
                        state_d = S_PRIMARY;
                        addr_d  = req_addr;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else begin
                    state_d = S_ALTERNATE;
                    alt_d   = ~pred_way;
                end
            end
            S_ALTERNATE: begin
                state_d = cmp_hit ? S_IDLE : S_REFILL;
            end
            S_REFILL: begin
                if (fill_valid) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign cmp_way  = (state_q == S_ALTERNATE) ? alt_q : pred_way;
    assign cur_addr = addr_q;

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_kind  = KIND_NONE;
        use_fill  = 1'b0;
        fill_req  = 1'b0;
        upd_en    = 1'b0;
        upd_way   = 1'b0;
        wr_en     = 1'b0;
        wr_way    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_PRIMARY: begin
                if (cmp_hit) begin
                    req_ready = 1'b1;
                    rsp_valid = 1'b1;
                    rsp_kind  = KIND_FAST;
                    upd_en    = 1'b1;
                    upd_way   = pred_way;
                end
            end
            S_ALTERNATE: begin
                if (cmp_hit) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = KIND_SLOW;
                    upd_en    = 1'b1;
                    upd_way   = alt_q;
                end
            end
            S_REFILL: begin
                fill_req = 1'b1;
                if (fill_valid) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = KIND_MISS;
                    use_fill  = 1'b1;
                    upd_en    = 1'b1;
                    upd_way   = lru_way;
                    wr_en     = 1'b1;
                    wr_way    = lru_way;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/waypred_cache.sv
module waypred_cache #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              pred_way, lru_way, cmp_way, cmp_hit;
    logic              use_fill, upd_en, upd_way, wr_en, wr_way;

    logic [wpc_pkg::NUM_WAYS-1:0]             way_vld;
    logic [wpc_pkg::NUM_WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [wpc_pkg::NUM_WAYS-1:0][DATA_W-1:0] way_dat;

    assign cur_idx = cur_addr[IDX_W-1:0];
    assign cur_tag = cur_addr[ADDR_W-1:IDX_W];

    wpc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .pred_way   (pred_way),
        .lru_way    (lru_way),
        .cmp_hit    (cmp_hit),
        .fill_valid (fill_valid),
        .cur_addr   (cur_addr),
        .cmp_way    (cmp_way),
        .rsp_valid  (rsp_valid),
        .rsp_kind   (rsp_kind),
        .use_fill   (use_fill),
        .fill_req   (fill_req),
        .upd_en     (upd_en),
        .upd_way    (upd_way),
        .wr_en      (wr_en),
        .wr_way     (wr_way)
    );

    wpc_ways #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ways (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (way_vld),
        .rd_tag   (way_tag),
        .rd_data  (way_dat),
        .wr_en    (wr_en),
        .wr_way   (wr_way),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_data  (fill_data)
    );

    wpc_hint #(.IDX_W(IDX_W)) u_hint (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (cur_idx),
        .pred_way (pred_way),
        .lru_way  (lru_way),
        .upd_en   (upd_en),
        .upd_way  (upd_way)
    );

    // single comparator, steered by the way under test this cycle
    assign cmp_hit   = way_vld[cmp_way] && (way_tag[cmp_way] == cur_tag);
    // data mux is set by the way select, not by the compare result
    assign rsp_data  = use_fill ? fill_data : way_dat[cmp_way];
    assign fill_addr = cur_addr;
endmodule

// File: rtl/wpc_chk.sv
module wpc_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic [DATA_W-1:0] rsp_data,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_valid,
    input logic [DATA_W-1:0] fill_data
);
    p_kind_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_kind == 2'd0);
    p_kind_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_kind != 2'd0);
    p_fast_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd1) |-> $past(req_valid && req_ready));
    p_slow_after_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd2) |-> (!req_ready && $past(!req_ready)));
    p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));
    p_miss_with_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd3) |-> (fill_valid && fill_req && rsp_data == fill_data));
    p_ready_low_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready);
    p_stray_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_req) |-> !rsp_valid);
endmodule

bind waypred_cache wpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .rsp_data   (rsp_data),
    .fill_req   (fill_req),
    .fill_addr  (fill_addr),
    .fill_valid (fill_valid),
    .fill_data  (fill_data)
);

// File: tb/tb_waypred_cache.sv
module tb_waypred_cache;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int ADDR_W     = 12;
    localparam int IDX_W      = 3;
    localparam int DATA_W     = 32;
    localparam int SETS       = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              req_ready;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic              fill_req;
    logic [ADDR_W-1:0] fill_addr;
    logic              fill_valid;
    logic [DATA_W-1:0] fill_data;

    waypred_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_data(rsp_data), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors     = 0;
    int miscompares = 0;
    bit done        = 1'b0;

    // behavioural model
    int m_tag  [SETS][2];
    bit m_vld  [SETS][2];
    bit m_pred [SETS];
    bit m_lru  [SETS];

    function automatic logic [DATA_W-1:0] memval(input logic [ADDR_W-1:0] a);
        return {4'hA, a, ~a, 4'h5};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_cycle(input string req, input bit e_rv, input logic [1:0] e_kind,
                             input bit e_rdy, input bit e_fr, input logic [DATA_W-1:0] e_dat);
        chk(req, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk(req, "rsp_kind",  64'(rsp_kind),  64'(e_kind));
        chk(req, "req_ready", 64'(req_ready), 64'(e_rdy));
        chk(req, "fill_req",  64'(fill_req),  64'(e_fr));
        if (e_rv) chk(req, "rsp_data", 64'(rsp_data), 64'(e_dat));
    endtask

    function automatic int predict(input logic [ADDR_W-1:0] a);
        int s = int'(a[IDX_W-1:0]);
        int t = int'(a[ADDR_W-1:IDX_W]);
        bit p = m_pred[s];
        if (m_vld[s][p] && m_tag[s][p] == t) return 1;
        if (m_vld[s][!p] && m_tag[s][!p] == t) return 2;
        return 3;
    endfunction

    function automatic void touch(input int s, input bit w);
        m_pred[s] = w;
        m_lru[s]  = !w;
    endfunction

    task automatic access(input logic [ADDR_W-1:0] a, input int lat, input string req);
        int s = int'(a[IDX_W-1:0]);
        int t = int'(a[ADDR_W-1:IDX_W]);
        int k = predict(a);
        bit v;
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid  = 1'b1;
        req_addr   = a;
        #QTR;
        chk("R6", "accept ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        #QTR;
        if (k == 1) begin
            chk_cycle(req, 1'b1, 2'd1, 1'b1, 1'b0, memval(a));
            touch(s, m_pred[s]);
            return;
        end
        chk_cycle("R6", 1'b0, 2'd0, 1'b0, 1'b0, '0);
        @(negedge clk);
        #QTR;
        if (k == 2) begin
            chk_cycle(req, 1'b1, 2'd2, 1'b0, 1'b0, memval(a));
            touch(s, !m_pred[s]);
            return;
        end
        chk_cycle("R4", 1'b0, 2'd0, 1'b0, 1'b0, '0);
        for (int c = 0; c <= lat; c++) begin
            @(negedge clk);
            if (c == lat) begin
                fill_valid = 1'b1;
                fill_data  = memval(a);
            end
            #QTR;
            chk("R4", "fill_addr", 64'(fill_addr), 64'(a));
            if (c < lat) chk_cycle("R6", 1'b0, 2'd0, 1'b0, 1'b1, '0);
            else         chk_cycle(req, 1'b1, 2'd3, 1'b0, 1'b1, memval(a));
        end
        v = m_lru[s];
        m_vld[s][v] = 1'b1;
        m_tag[s][v] = t;
        touch(s, v);
    endtask

    // two requests, both expected to hit their predicted way
    task automatic stream2(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid  = 1'b1;
        req_addr   = a;
        #QTR;
        chk("R7", "ready first", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_addr = b;
        #QTR;
        chk_cycle("R7", 1'b1, 2'd1, 1'b1, 1'b0, memval(a));
        @(negedge clk);
        req_valid = 1'b0;
        #QTR;
        chk_cycle("R7", 1'b1, 2'd1, 1'b1, 1'b0, memval(b));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [ADDR_W-1:0] ra;
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 1'b0;
            m_lru[s]  = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 1'b0;
                m_tag[s][w] = 0;
            end
        end
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        fill_valid = 1'b0; fill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #QTR;
        chk_cycle("R1", 1'b0, 2'd0, 1'b1, 1'b0, '0);

        // set 3: A tag1, B tag2, C tag5
        access(12'h00B, 2, "R1");   // nothing valid after reset: miss
        access(12'h00B, 0, "R2");
        access(12'h013, 0, "R5");   // fills way 1 (replacement bit)
        access(12'h00B, 0, "R3");   // prediction names way 1: slow
        access(12'h00B, 0, "R3");   // now fast after update
        access(12'h013, 0, "R3");
        access(12'h02B, 1, "R5");   // evicts A
        access(12'h00B, 3, "R5");   // A misses again, evicts B
        access(12'h013, 0, "R5");   // B gone: miss
        access(12'h03D, 0, "R4");   // set 5
        stream2(12'h013, 12'h03D);
        stream2(12'h03D, 12'h03D);

        // stray refill pulse while idle
        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = 32'hDEAD_BEEF;
        #QTR;
        chk_cycle("R8", 1'b0, 2'd0, 1'b1, 1'b0, '0);
        @(negedge clk);
        fill_valid = 1'b0;
        #QTR;
        chk_cycle("R8", 1'b0, 2'd0, 1'b1, 1'b0, '0);
        access(12'h03D, 0, "R8");
        access(12'h013, 0, "R8");

        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = {7'd0, lfsr[4:3], lfsr[2:0]};
            access(ra, i % 4, "R2");
        end

        @(negedge clk);
        #QTR;
        chk_cycle("R9", 1'b0, 2'd0, 1'b1, 1'b0, '0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule